// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address sequence that a synchronous DRAM walks through during one burst. A controller pulses `load` with a start column, a burst length code and a wrap mode. From the next clock on, the block presents one column address per cycle with `col_valid` high. It flags the final address of a fixed-length burst on `col_last`.

Four fixed lengths (1, 2, 4 and 8 beats) and a full-page mode are supported. Fixed bursts wrap inside the aligned block the start column falls in, using either an incrementing order or an XOR (interleaved) order. A full-page burst walks the whole page, wrapping at its end, until `stop` is pulsed.

A fresh `load` is accepted on any clock, including every consecutive clock. It abandons whatever burst is running, so random column access at full rate is possible. Rows, banks and data are handled elsewhere.

Top module: `sdram_col_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the following cycle shows `col_valid`=0, `col_last`=0 and `col_addr`=0.
- R2: A `load` at an edge makes the next cycle show `col_valid`=1 and `col_addr` equal to the loaded `start_col`.
- R3: With `wrap_il`=0 and a length L of 2, 4 or 8, beat k carries low log2(L) bits equal to (start + k) mod L. The remaining upper bits equal those of the start column.
- R4: With `wrap_il`=1 and a length L of 2, 4 or 8, beat k carries low bits equal to the start's low bits XOR k. The upper bits stay those of the start column.
- R5: `bl_code` encoding: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives full page. Codes 4, 5 and 6 give 1 beat. A fixed burst shows exactly L valid cycles, after which `col_valid` falls unless a new `load` arrives.
- R6: `col_last` is high exactly on the last valid beat of a fixed-length burst. It is never high in full-page mode.
- R7: In full-page mode (code 7), beat k shows (start + k) mod 2^COL_W, whatever `wrap_il` says. The burst runs until stopped.
- R8: `stop` without `load` during a burst makes `col_valid` low in the next cycle, for fixed and full-page bursts alike. When `load` and `stop` arrive together, `load` wins. `stop` while idle has no effect.
- R9: A `load` during a running burst restarts at beat 0 of the new burst in the next cycle, and this may repeat on every clock.
- R10: `col_addr` is 0 in every cycle where `col_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Start a new burst at `start_col` |
| start_col | input | COL_W | First column of the burst |
| bl_code | input | 3 | Burst length code (see R5) |
| wrap_il | input | 1 | 1 = interleaved order, 0 = sequential |
| stop | input | 1 | Terminate the running burst |
| col_valid | output | 1 | A column address is presented this cycle |
| col_addr | output | COL_W | Current column address |
| col_last | output | 1 | Final beat of a fixed-length burst |

## Verification
The hardest situations to reach are the interruptions. These are a `load` arriving on the very cycle a burst would end, `load` and `stop` asserted together, and back-to-back loads on every clock. The stimulus drives these collisions deliberately, with start columns whose low bits sit near the wrap point. A full-page burst is started three columns before the page end so that the wrap across the page boundary is seen before it is stopped.

// File: rtl/col_seq_pkg.sv
`timescale 1ns/1ps
package col_seq_pkg;
  // Burst length codes; the length is 2**code for codes 0..3.
  localparam logic [2:0] BLC_1    = 3'd0;
  localparam logic [2:0] BLC_2    = 3'd1;
  localparam logic [2:0] BLC_4    = 3'd2;
  localparam logic [2:0] BLC_8    = 3'd3;
  localparam logic [2:0] BLC_PAGE = 3'd7;

  typedef enum logic {
    ORDER_SEQ = 1'b0,
    ORDER_XOR = 1'b1
  } order_e;
endpackage

// File: rtl/col_seq_ctrl.sv
`timescale 1ns/1ps
module col_seq_ctrl
  import col_seq_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       bl_code,
  input  logic             wrap_il,
  input  logic             stop,
  output logic             nxt_active,
  output logic [COL_W-1:0] nxt_base,
  output logic [COL_W-1:0] nxt_beat,
  output logic [COL_W-1:0] nxt_mask,
  output order_e           nxt_order,
  output logic             nxt_last
);
  localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

  logic             act_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] mask_q;
  logic             page_q;
  order_e           order_q;

  logic [COL_W-1:0] mask_in;
  logic             page_in;
  logic             page_n;
  logic             cur_last;

  // length code -> mask of the bits that move within the burst
  always_comb begin
    case (bl_code)
      BLC_2:    mask_in = COL_W'(1);
      BLC_4:    mask_in = COL_W'(3);
      BLC_8:    mask_in = COL_W'(7);
      BLC_PAGE: mask_in = ALL_ONES;
      default:  mask_in = '0;
    endcase
  end
  assign page_in  = (bl_code == BLC_PAGE);
  assign cur_last = act_q && !page_q && (beat_q == mask_q);

  always_comb begin
    nxt_active = act_q;
    nxt_base   = base_q;
    nxt_beat   = beat_q;
    nxt_mask   = mask_q;
    nxt_order  = order_q;
    page_n     = page_q;
    if (load) begin
      nxt_active = 1'b1;
      nxt_base   = start_col;
      nxt_beat   = '0;
      nxt_mask   = mask_in;
      page_n     = page_in;
      nxt_order  = (wrap_il && !page_in) ? ORDER_XOR : ORDER_SEQ;
    end else if (act_q && (stop || cur_last)) begin
      nxt_active = 1'b0;
      nxt_beat   = '0;
    end else if (act_q) begin
      nxt_beat   = beat_q + COL_W'(1);
    end
  end

  assign nxt_last = nxt_active && !page_n && (nxt_beat == nxt_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      base_q  <= '0;
      beat_q  <= '0;
      mask_q  <= '0;
      page_q  <= 1'b0;
      order_q <= ORDER_SEQ;
    end else begin
      act_q   <= nxt_active;
      base_q  <= nxt_base;
      beat_q  <= nxt_beat;
      mask_q  <= nxt_mask;
      page_q  <= page_n;
      order_q <= nxt_order;
    end
  end

  // R5: a fixed burst never counts past its final beat
  a_r5_beat_in_range: assert property (@(posedge clk) disable iff (rst)
    (act_q && !page_q) |-> (beat_q <= mask_q));

  // R9: a load always restarts at beat zero
  a_r9_restart: assert property (@(posedge clk) disable iff (rst)
    load |=> (act_q && beat_q == '0));
endmodule

// File: rtl/col_seq_addr.sv
`timescale 1ns/1ps
module col_seq_addr
  import col_seq_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             active,
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  order_e           order,
  output logic [COL_W-1:0] addr
);
  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] raw;

  assign sum = base + beat;

  // per bit: fixed upper bits keep the start value, moving bits follow the order
  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign raw[i] = !mask[i]            ? base[i] :
                    (order == ORDER_XOR) ? (base[i] ^ beat[i]) : sum[i];
  end

  assign addr = active ? raw : '0;
endmodule

// File: rtl/sdram_col_seq.sv
`timescale 1ns/1ps
module sdram_col_seq
  import col_seq_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       bl_code,
  input  logic             wrap_il,
  input  logic             stop,
  output logic             col_valid,
  output logic [COL_W-1:0] col_addr,
  output logic             col_last
);
  logic             n_active;
  logic [COL_W-1:0] n_base;
  logic [COL_W-1:0] n_beat;
  logic [COL_W-1:0] n_mask;
  order_e           n_order;
  logic             n_last;
  logic [COL_W-1:0] n_addr;

  col_seq_ctrl #(.COL_W(COL_W)) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .start_col  (start_col),
    .bl_code    (bl_code),
    .wrap_il    (wrap_il),
    .stop       (stop),
    .nxt_active (n_active),
    .nxt_base   (n_base),
    .nxt_beat   (n_beat),
    .nxt_mask   (n_mask),
    .nxt_order  (n_order),
    .nxt_last   (n_last)
  );

  col_seq_addr #(.COL_W(COL_W)) i_addr (
    .active (n_active),
    .base   (n_base),
    .beat   (n_beat),
    .mask   (n_mask),
    .order  (n_order),
    .addr   (n_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      col_valid <= 1'b0;
      col_addr  <= '0;
      col_last  <= 1'b0;
    end else begin
      col_valid <= n_active;
      col_addr  <= n_addr;
      col_last  <= n_last;
    end
  end

  // R1: reset clears all outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!col_valid && !col_last && col_addr == '0));

  // R2: first beat is the loaded column
  a_r2_first_beat: assert property (@(posedge clk) disable iff (rst)
    load |=> (col_valid && col_addr == $past(start_col)));

  // R6: last flag only on a valid beat
  a_r6_last_valid: assert property (@(posedge clk) disable iff (rst)
    col_last |-> col_valid);

  // R8: stop without load ends the burst
  a_r8_stop_ends: assert property (@(posedge clk) disable iff (rst)
    (stop && !load) |=> !col_valid);

  // R10: address is zero while idle
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !col_valid |-> (col_addr == '0));
endmodule

// File: tb/test_sdram_col_seq.sv
`timescale 1ns/1ps
module test_sdram_col_seq;
  localparam int COL_W = 9;
  localparam int PAGE  = 1 << COL_W;
  localparam time TCK  = 5ns;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             load = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0]       bl_code = 3'd0;
  logic             wrap_il = 1'b0;
  logic             stop = 1'b0;
  logic             col_valid;
  logic [COL_W-1:0] col_addr;
  logic             col_last;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  // reference state
  bit m_act = 0;
  int m_start = 0, m_k = 0, m_len = 1;
  bit m_il = 0;

  always #(TCK/2) clk = ~clk;

  sdram_col_seq #(.COL_W(COL_W)) i_sdram_col_seq (
    .clk(clk), .rst(rst), .load(load), .start_col(start_col),
    .bl_code(bl_code), .wrap_il(wrap_il), .stop(stop),
    .col_valid(col_valid), .col_addr(col_addr), .col_last(col_last)
  );

  function automatic int len_of(input int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 0; // full page
      default: return 1;
    endcase
  endfunction

  function automatic int exp_addr();
    int low, blk;
    if (!m_act) return 0;
    if (m_len == 0) return (m_start + m_k) % PAGE;
    low = m_start % m_len;
    blk = m_start - low;
    if (m_il) return blk + (low ^ m_k);
    return blk + ((low + m_k) % m_len);
  endfunction

  task automatic compare(input string tag);
    int ea;
    bit ev, el;
    ev = m_act;
    ea = exp_addr();
    el = m_act && (m_len != 0) && (m_k == m_len - 1);
    vectors++;
    if (col_valid !== ev || int'(col_addr) != ea || col_last !== el) begin
      misses++;
      $display("FAIL %s: actual valid=%0b addr=%0d last=%0b expected valid=%0b addr=%0d last=%0b",
               tag, col_valid, col_addr, col_last, ev, ea, el);
    end
  endtask

  task automatic step(input bit ld, input int sc, input int bc, input bit il,
                      input bit sp, input string tag);
    @(negedge clk);
    load = ld; start_col = COL_W'(sc); bl_code = 3'(bc); wrap_il = il; stop = sp;
    @(posedge clk);
    if (ld) begin
      m_act = 1; m_start = sc; m_k = 0; m_len = len_of(bc); m_il = il && (bc != 7);
    end else if (m_act && (sp || (m_len != 0 && m_k == m_len - 1))) begin
      m_act = 0;
    end else if (m_act) begin
      m_k = m_k + 1;
    end
    #1;
    compare(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
  endtask

  task automatic burst(input int sc, input int bc, input bit il, input string tag);
    step(1, sc, bc, il, 0, tag);
    idle(len_of(bc) + 1, tag);
  endtask

  initial begin
    // R1 reset
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1; compare("R1");
    @(negedge clk); rst = 1'b0;
    idle(2, "R10");

    burst(5, 0, 0, "R2/R5");
    burst(5, 1, 0, "R3/R6");
    burst(6, 2, 0, "R3/R6");
    burst(13, 3, 0, "R3/R6");
    burst(6, 2, 1, "R4/R6");
    burst(13, 3, 1, "R4/R6");
    burst(255, 1, 1, "R4");
    burst(9, 5, 1, "R5");

    // full page across the page end, interleave request ignored
    step(1, PAGE - 3, 7, 1, 0, "R7");
    idle(6, "R7/R6");
    step(0, 0, 0, 0, 1, "R8");
    idle(2, "R10");

    // stop inside a fixed burst, stop with load, stop while idle
    step(1, 20, 3, 0, 0, "R8");
    idle(2, "R8");
    step(0, 0, 0, 0, 1, "R8");
    step(0, 0, 0, 0, 1, "R8");
    step(1, 40, 2, 1, 0, "R8");
    step(1, 100, 2, 0, 1, "R8");
    idle(4, "R8");

    // back-to-back loads and a load on the last beat
    step(1, 3, 3, 0, 0, "R9");
    step(1, 77, 2, 1, 0, "R9");
    step(1, 300, 1, 0, 0, "R9");
    step(1, 511, 7, 0, 0, "R9");
    step(1, 42, 2, 0, 0, "R9");
    idle(3, "R9");
    step(1, 58, 2, 0, 0, "R9");
    idle(5, "R9/R10");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(TCK * 200000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog (R9 sequence): actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule